// File: doc/BRIEF.md
# Host Bus FIFO Burst-Read Port

This block is the read side of an asynchronous host bus placed in front of a receive data FIFO. The host drives active-low chip-select and read strobes, an address and a FIFO-select line. All of them are sampled by the block's own clock. A read cycle lasts while both strobes are low. When the FIFO-select line is high, the upper address bits are ignored and each completed cycle returns the next FIFO word. The host can therefore tie that line to a high address bit and stream reads back to back while its address keeps counting. When FIFO-select is low, the low address bits choose one of four read-only status words.

The port runs either as a full 32-bit bus or as a 16-bit bus. The bus width is chosen by a strap input. On the narrow bus only the lower data lanes are enabled, and the lowest address bit picks which half of the word is returned. The block drives the data lanes and two output enables, one for the lower half of the bus and one for the upper half. It issues a one-cycle pop to the FIFO and keeps a sticky flag that records a read from an empty FIFO.

Top module: `hbus_fifo_rdport`

## Requirements
- R1: A read cycle is active only while both `cs_n` and `rd_n` are low after synchronisation. `doe_lo` is high exactly during the active cycle. `doe_hi` is never high unless `doe_lo` is high.
- R2: With `fifo_sel` high at cycle start, `dout` returns the current FIFO head word whatever the value of `addr[6:3]`.
- R3: A pop is a single-cycle `fifo_pop` pulse. It is issued on the cycle in which the enables drop after a completed FIFO read. A strobe held low for any length causes at most one pop.
- R4: When `narrow_bus` is 1, `doe_hi` stays 0 and `dout[31:16]` reads 0. On `dout[15:0]`, `addr[0]`=0 returns word bits 15:0 and `addr[0]`=1 returns word bits 31:16.
- R5: On the narrow bus, a FIFO read with `addr[0]`=0 does not pop. Only the read of the upper half, with `addr[0]`=1, pops the entry.
- R6: A FIFO read while `fifo_empty` is high returns 0 and does not pop. It sets `underrun`, which then stays 1 until reset.
- R7: With `fifo_sel` low, `addr[2:1]` selects a status word and no pop occurs. The selections are: 0 gives `fifo_count` zero-extended; 1 gives {30 zeros, underrun, fifo_empty}; 2 gives the `IDENT` parameter (default 32'h5A1E0C3D); 3 gives 0.
- R8: The enables and data appear on the third rising clock edge after both strobes are sampled low. The pop appears on the third rising edge after a strobe is sampled high.
- R9: Back-to-back cycles are served without limit when the strobes go high for two clock cycles between reads, including bursts in which only `rd_n` toggles while `cs_n` stays low.
- R10: After reset `dout` is 0, and `doe_lo`, `doe_hi`, `fifo_pop` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| addr | input | 7 | Host half-word address (byte address bits 7..1) |
| fifo_sel | input | 1 | High selects the FIFO path and bypasses decode |
| narrow_bus | input | 1 | Strap: 1 for a 16-bit data bus |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO has no entries |
| fifo_count | input | 8 | FIFO occupancy |
| fifo_pop | output | 1 | One-cycle request to remove the head entry |
| dout | output | 32 | Data to the host bus pads |
| doe_lo | output | 1 | Output enable for data lanes 15:0 |
| doe_hi | output | 1 | Output enable for data lanes 31:16 |
| underrun | output | 1 | Sticky flag: a FIFO read found it empty |

## Verification
The assertions check on every cycle the relations that can be stated as properties. These are: single-cycle pops that coincide with the enables falling; enable start tied to strobes sampled two edges earlier; upper-lane enable never on a narrow bus or without the lower one; and the underrun flag never clearing. Only the scenarios in the bench can show that the right word, half-word or status value reaches `dout`. The same holds for ignoring the upper address bits, holding back the pop until the upper half is read, and giving exactly one pop for a long strobe. Back-to-back bursts with minimum gaps are likewise shown only by those scenarios.

// File: rtl/hfr_pkg.sv
package hfr_pkg;
   typedef enum logic [1:0] {
      REG_LEVEL = 2'd0,
      REG_FLAGS = 2'd1,
      REG_IDENT = 2'd2,
      REG_SPARE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/hfr_sync.sv
module hfr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '1;
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hfr_cycle.sv
module hfr_cycle (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic rd_s,
   output logic start,
   output logic finish,
   output logic busy
);
   logic active;
   logic active_q;

   assign active = ~cs_s & ~rd_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active;
   end

   assign start  = active & ~active_q;
   assign finish = ~active & active_q;
   assign busy   = active_q;
endmodule

// File: rtl/hfr_lane.sv
module hfr_lane #(
   parameter int DATA_W = 32
) (
   input  logic              narrow,
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] word_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] half;

   assign half   = hi_sel ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
   assign word_o = narrow ? {{HALF_W{1'b0}}, half} : word_i;
endmodule

// File: rtl/hbus_fifo_rdport.sv
module hbus_fifo_rdport
   import hfr_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                ADDR_W      = 7,
   parameter int                CNT_W       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] IDENT       = 32'h5A1E_0C3D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              fifo_sel,
   input  logic              narrow_bus,
   input  logic [DATA_W-1:0] fifo_rdata,
   input  logic              fifo_empty,
   input  logic [CNT_W-1:0]  fifo_count,
   output logic              fifo_pop,
   output logic [DATA_W-1:0] dout,
   output logic              doe_lo,
   output logic              doe_hi,
   output logic              underrun
);
   localparam int FLAG_PAD = DATA_W - 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must cover the half and register select bits");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must fit in a data word");
   end

   logic [1:0]        strb_s;
   logic              cyc_start;
   logic              cyc_finish;
   logic              cyc_busy;
   logic [DATA_W-1:0] reg_word;
   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] lane_word;
   logic [DATA_W-1:0] dout_q;
   logic              pop_plan;
   logic              unused_addr_hi;

   assign unused_addr_hi = ^addr[ADDR_W-1:3];

   hfr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, rd_n}),
      .q     (strb_s)
   );

   hfr_cycle u_cycle (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_s   (strb_s[1]),
      .rd_s   (strb_s[0]),
      .start  (cyc_start),
      .finish (cyc_finish),
      .busy   (cyc_busy)
   );

   always_comb begin
      case (reg_sel_e'(addr[2:1]))
         REG_LEVEL: reg_word = DATA_W'(fifo_count);
         REG_FLAGS: reg_word = {{FLAG_PAD{1'b0}}, underrun, fifo_empty};
         REG_IDENT: reg_word = IDENT;
         default:   reg_word = '0;
      endcase
   end

   assign src_word = fifo_sel ? (fifo_empty ? '0 : fifo_rdata) : reg_word;

   hfr_lane #(.DATA_W(DATA_W)) u_lane (
      .narrow (narrow_bus),
      .hi_sel (addr[0]),
      .word_i (src_word),
      .word_o (lane_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         pop_plan <= 1'b0;
         underrun <= 1'b0;
         fifo_pop <= 1'b0;
      end else begin
         fifo_pop <= cyc_finish & pop_plan;
         if (cyc_start) begin
            dout_q   <= lane_word;
            pop_plan <= fifo_sel & ~fifo_empty & (~narrow_bus | addr[0]);
            if (fifo_sel & fifo_empty) underrun <= 1'b1;
         end
      end
   end

   assign dout   = dout_q;
   assign doe_lo = cyc_busy;
   assign doe_hi = cyc_busy & ~narrow_bus;
endmodule

// File: rtl/hfr_checker.sv
module hfr_checker (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic rd_n,
   input logic narrow_bus,
   input logic doe_lo,
   input logic doe_hi,
   input logic fifo_pop,
   input logic underrun
);
   assert_upper_off_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      doe_hi |-> !narrow_bus);

   assert_upper_needs_lower_R1: assert property (@(posedge clk) disable iff (!rst_n)
      doe_hi |-> doe_lo);

   assert_start_after_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(doe_lo) |-> $past(!cs_n && !rd_n, 2));

   assert_pop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop);

   assert_pop_at_cycle_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> $fell(doe_lo));

   assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

bind hbus_fifo_rdport hfr_checker u_hfr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .rd_n       (rd_n),
   .narrow_bus (narrow_bus),
   .doe_lo     (doe_lo),
   .doe_hi     (doe_hi),
   .fifo_pop   (fifo_pop),
   .underrun   (underrun)
);

// File: tb/tb_hbus_fifo_rdport.sv
module tb_hbus_fifo_rdport;
   localparam logic [31:0] ID_VAL = 32'h5A1E_0C3D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [6:0]  addr = '0;
   logic        fifo_sel = 1'b0;
   logic        narrow_bus = 1'b0;
   logic [31:0] mem [16];
   logic [4:0]  wp = '0;
   logic [4:0]  rp = '0;
   logic [4:0]  exp_rp = '0;
   logic [31:0] fifo_rdata;
   logic        fifo_empty;
   logic [7:0]  fifo_count;
   logic        fifo_pop;
   logic [31:0] dout;
   logic        doe_lo;
   logic        doe_hi;
   logic        underrun;

   int checks = 0;
   int errors = 0;
   int pops_seen = 0;
   int exp_pops = 0;
   bit exp_under = 1'b0;
   bit done = 1'b0;
   logic [31:0] expq [$];
   string       tagq [$];

   always #5 clk = ~clk;

   assign fifo_rdata = mem[rp[3:0]];
   assign fifo_empty = (wp == rp);
   assign fifo_count = 8'(wp - rp);

   hbus_fifo_rdport dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
      .fifo_sel(fifo_sel), .narrow_bus(narrow_bus), .fifo_rdata(fifo_rdata),
      .fifo_empty(fifo_empty), .fifo_count(fifo_count), .fifo_pop(fifo_pop),
      .dout(dout), .doe_lo(doe_lo), .doe_hi(doe_hi), .underrun(underrun)
   );

   always @(posedge clk) begin
      if (fifo_pop) begin
         rp        <= rp + 5'd1;
         pops_seen <= pops_seen + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] v);
      mem[wp[3:0]] = v;
      wp = wp + 5'd1;
   endtask

   function automatic logic [31:0] pick(input logic [31:0] w, input logic a0);
      if (!narrow_bus) return w;
      return {16'h0, a0 ? w[31:16] : w[15:0]};
   endfunction

   // Driver: predicts the result, queues it, then runs one host read cycle.
   task automatic rd(input logic [6:0] a, input bit fs, input int hold, input int gap,
                     input bit rd_only, input string tag);
      logic [31:0] w;
      bit emp;
      emp = (wp == exp_rp);
      if (fs) begin
         w = emp ? 32'h0 : mem[exp_rp[3:0]];
         if (!emp && (!narrow_bus || a[0])) begin
            exp_rp = exp_rp + 5'd1;
            exp_pops++;
         end
      end else begin
         case (a[2:1])
            2'd0:    w = 32'(wp - exp_rp);
            2'd1:    w = {30'h0, exp_under, emp};
            2'd2:    w = ID_VAL;
            default: w = 32'h0;
         endcase
      end
      expq.push_back(pick(w, a[0]));
      tagq.push_back(tag);
      if (fs && emp) exp_under = 1'b1;
      @(negedge clk);
      addr = a; fifo_sel = fs; cs_n = 1'b0; rd_n = 1'b0;
      repeat (hold) @(negedge clk);
      rd_n = 1'b1;
      if (!rd_only) cs_n = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   // Monitor: compares each started cycle's data against the scoreboard.
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && doe_lo && !prev_oe) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R1 read without request", dout, 32'h0);
         end else begin
            automatic logic [31:0] e = expq.pop_front();
            automatic string t = tagq.pop_front();
            chk(dout === e, t, dout, e);
            chk(doe_hi === !narrow_bus, "R4 upper lane enable", 32'(doe_hi), 32'(!narrow_bus));
         end
      end
      prev_oe <= doe_lo;
   end

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout == 32'h0,  "R10 reset dout", dout, 32'h0);
      chk(doe_lo == 1'b0, "R10 reset doe_lo", 32'(doe_lo), 32'h0);
      chk(doe_hi == 1'b0, "R10 reset doe_hi", 32'(doe_hi), 32'h0);
      chk(fifo_pop == 1'b0, "R10 reset pop", 32'(fifo_pop), 32'h0);
      chk(underrun == 1'b0, "R10 reset underrun", 32'(underrun), 32'h0);

      for (int i = 0; i < 10; i++) push(32'hC0DE_0000 + 32'(i * 32'h0001_0101));

      // R8 latency of enables and pop
      expq.push_back(mem[exp_rp[3:0]]);
      tagq.push_back("R8 first word");
      exp_rp = exp_rp + 5'd1; exp_pops++;
      addr = 7'h00; fifo_sel = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(doe_lo == 1'b0, "R8 enable not before third edge", 32'(doe_lo), 32'h0);
      @(negedge clk);
      chk(doe_lo == 1'b1, "R8 enable on third edge", 32'(doe_lo), 32'h1);
      repeat (3) @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(doe_lo == 1'b1 && fifo_pop == 1'b0, "R8 still busy before third edge", {doe_lo, fifo_pop}, 2'b10);
      @(negedge clk);
      chk(doe_lo == 1'b0 && fifo_pop == 1'b1, "R3 pop as enables drop", {doe_lo, fifo_pop}, 2'b01);
      repeat (3) @(negedge clk);

      // R2 FIFO path ignores upper address bits
      rd(7'h7C, 1'b1, 4, 5, 1'b0, "R2 fifo read addr 7C");
      rd(7'h03, 1'b1, 4, 5, 1'b0, "R2 fifo read addr 03");
      rd(7'h5A, 1'b1, 4, 5, 1'b0, "R2 fifo read addr 5A");
      chk(pops_seen == exp_pops, "R2 pop count", 32'(pops_seen), 32'(exp_pops));

      // R7 status words, no pop
      rd(7'h60, 1'b0, 4, 5, 1'b0, "R7 level word");
      rd(7'h42, 1'b0, 4, 5, 1'b0, "R7 flags word");
      rd(7'h04, 1'b0, 4, 5, 1'b0, "R7 ident word");
      rd(7'h06, 1'b0, 4, 5, 1'b0, "R7 spare word");
      chk(pops_seen == exp_pops, "R7 no pop on status", 32'(pops_seen), 32'(exp_pops));

      // R3 long strobe pops once
      rd(7'h10, 1'b1, 20, 5, 1'b0, "R3 long strobe data");
      chk(pops_seen == exp_pops, "R3 single pop for long strobe", 32'(pops_seen), 32'(exp_pops));

      // R9 rd_n-only burst with two-cycle gaps
      rd(7'h20, 1'b1, 3, 1, 1'b1, "R9 burst word 0");
      rd(7'h21, 1'b1, 3, 1, 1'b1, "R9 burst word 1");
      rd(7'h22, 1'b1, 3, 1, 1'b1, "R9 burst word 2");
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(pops_seen == exp_pops, "R9 burst pops", 32'(pops_seen), 32'(exp_pops));

      // R1 chip select alone starts nothing
      cs_n = 1'b0; rd_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(doe_lo == 1'b0, "R1 cs_n alone no enable", 32'(doe_lo), 32'h0);
      end
      cs_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 and R5 narrow bus halves
      narrow_bus = 1'b1;
      @(negedge clk);
      rd(7'h00, 1'b1, 4, 5, 1'b0, "R4 low half");
      chk(pops_seen == exp_pops, "R5 no pop after low half", 32'(pops_seen), 32'(exp_pops));
      rd(7'h01, 1'b1, 4, 5, 1'b0, "R4 high half");
      chk(pops_seen == exp_pops, "R5 pop after high half", 32'(pops_seen), 32'(exp_pops));
      narrow_bus = 1'b0;
      @(negedge clk);

      // drain, then R6 empty reads
      rd(7'h00, 1'b1, 4, 5, 1'b0, "R2 last word");
      rd(7'h00, 1'b1, 4, 5, 1'b0, "R6 empty read returns zero");
      chk(underrun == 1'b1, "R6 underrun set", 32'(underrun), 32'h1);
      chk(pops_seen == exp_pops, "R6 no pop when empty", 32'(pops_seen), 32'(exp_pops));
      rd(7'h02, 1'b0, 4, 5, 1'b0, "R6 flags show underrun");
      rd(7'h00, 1'b0, 4, 5, 1'b0, "R7 level zero when empty");
      rd(7'h08, 1'b1, 4, 5, 1'b0, "R6 second empty read");
      chk(underrun == 1'b1, "R6 underrun stays set", 32'(underrun), 32'h1);

      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R1 all reads seen", 32'(expq.size()), 32'h0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule